// File: doc/BRIEF.md
# Cascadable Configuration Bitstream Streamer

This block holds a fixed configuration bitstream in a small on-chip ROM and plays it out to a downstream configuration port. It has no clock of its own. The consumer, or a free-running oscillator, supplies the clock. On every rising edge where the block is selected, it moves to the next data item. The consumer captures that item on the following rising edge.

Two widths are supported. In serial mode the block sends one bit per edge on bit 0 of the bus. Bits go out most significant first within each stored byte. In parallel mode it sends one whole byte per edge. The output enable flag stands in for tri-stating the pins.

Several devices can share one clock and one data bus. Each device's cascade output drives the chip enable of the next device. The stream then passes from one device to the next with no gap and no overlap. Holding the output-enable/reset input low puts the block back at the start of its data.

Top module: `cfgs_stream`

## Requirements
- R1: `data_oe` is 1 during the cycle after a rising edge at which `chip_en` and `out_en` were both 1 and the data was not yet exhausted. Otherwise it is 0. While `data_oe` is 0, `data_out` reads 8'h00.
- R2: Stored byte i, for i from 0 to LEN-1, equals the low 8 bits of ((i*29 + SEED) XOR (i >> 2)).
- R3: In parallel mode (`par_mode`=1), the k-th enabled edge after reset puts stored byte k-1 on `data_out[7:0]`.
- R4: In serial mode (`par_mode`=0), each enabled edge puts one bit on `data_out[0]` and holds `data_out[7:1]` at 0. The bits of each byte go out from bit 7 down to bit 0. The block moves to the next byte after the eighth bit.
- R5: An edge with `chip_en` at 0 does not advance the read position. The next enabled edge presents the item that would have come next.
- R6: `casc_en` rises at the same edge that presents the last item: byte LEN-1 in parallel mode, or bit 0 of byte LEN-1 in serial mode. It then stays at 1 until `out_en` is sampled low.
- R7: Once the data is exhausted, further enabled edges present nothing. `data_oe` stays 0 and the read position does not wrap back to byte 0.
- R8: An edge with `out_en` at 0 clears the read position, `casc_en` and `data_oe`. The next stream starts again at byte 0, bit 7.
- R9: Take two devices on one clock and one `out_en`, with the second device's `chip_en` driven by the first device's `casc_en`. Their `data_oe` flags are never both 1. The second device's first item follows the first device's last item on the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock from the consumer or an external oscillator |
| chip_en | input | 1 | Device select, active high; driven by the previous device's `casc_en` in a chain |
| out_en | input | 1 | Output enable; low acts as a synchronous reset |
| par_mode | input | 1 | 1 = byte-wide output, 0 = serial output on bit 0 |
| data_out | output | 8 | Data item presented to the consumer |
| data_oe | output | 1 | 1 while the block drives `data_out`; 0 stands for high impedance |
| casc_en | output | 1 | Enables the next device once this device's data is exhausted |

## Verification
The bench targets the end of the data.

- It checks that the cascade flag rises on the edge that presents the last item. If the flag came one edge late, the chain would leave a one-cycle gap in the stream. If it came one edge early, two devices would drive the bus at once.
- It looks at the edges after exhaustion. A design that wrapped its address back to zero would present byte 0 again there.
- In serial mode it checks the bit order and the byte step after the eighth bit. An off-by-one in the bit counter repeats a bit or skips one.
- It pauses `chip_en` and resets in the middle of a stream. This catches a pointer that keeps running while deselected, and one that is not cleared by reset.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

  // Content of stored byte idx for a given seed.
  function automatic logic [7:0] cfgs_byte(input int unsigned idx, input logic [7:0] seed);
    int unsigned mix;
    mix = (idx * 29 + 32'(seed)) ^ (idx >> 2);
    return mix[7:0];
  endfunction

endpackage

// File: rtl/cfgs_rom.sv
// Read-only store with a registered read port, so block RAM can be inferred.
module cfgs_rom #(
  parameter int          LEN    = 32,
  parameter logic [7:0]  SEED   = 8'h5A,
  parameter int          ADDR_W = $clog2(LEN + 1)
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int IDX_W = (LEN > 1) ? $clog2(LEN) : 1;

  logic [7:0] tbl [LEN];

  for (genvar g = 0; g < LEN; g++) begin : g_fill
    assign tbl[g] = cfgs_pkg::cfgs_byte(g, SEED);
  end

  always_ff @(posedge clk) begin
    if (raddr < ADDR_W'(LEN)) rdata <= tbl[raddr[IDX_W-1:0]];
    else                      rdata <= 8'h00;
  end
endmodule

// File: rtl/cfgs_seq.sv
// Tracks the read position (byte address and bit index) and the exhaustion flag.
module cfgs_seq #(
  parameter int LEN    = 32,
  parameter int ADDR_W = $clog2(LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              par,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] addr_nxt,
  output logic [2:0]        bit_idx,
  output logic              done
);
  logic [2:0] bit_nxt;
  logic       done_nxt;
  logic       last_item;
  logic       byte_end;

  always_comb begin
    byte_end  = par || (bit_idx == 3'd7);
    last_item = (addr == ADDR_W'(LEN - 1)) && byte_end;
    addr_nxt  = addr;
    bit_nxt   = bit_idx;
    done_nxt  = done;
    if (rst) begin
      addr_nxt = '0;
      bit_nxt  = 3'd0;
      done_nxt = 1'b0;
    end else if (step) begin
      if (byte_end) begin
        addr_nxt = addr + 1'b1;
        bit_nxt  = 3'd0;
      end else begin
        bit_nxt  = bit_idx + 3'd1;
      end
      done_nxt = last_item;
    end
  end

  always_ff @(posedge clk) begin
    addr    <= addr_nxt;
    bit_idx <= bit_nxt;
    done    <= done_nxt;
  end
endmodule

// File: rtl/cfgs_out.sv
// Output register: selects the whole byte or one bit and registers data and enable.
module cfgs_out (
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       par,
  input  logic [7:0] rom_q,
  input  logic [2:0] bit_idx,
  output logic [7:0] dout,
  output logic       doe
);
  logic [7:0] item;

  always_comb begin
    if (par) item = rom_q;
    else     item = {7'b0, rom_q[3'd7 - bit_idx]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= 8'h00;
      doe  <= 1'b0;
    end else begin
      doe  <= step;
      dout <= step ? item : 8'h00;
    end
  end
endmodule

// File: rtl/cfgs_stream.sv
module cfgs_stream #(
  parameter int         LEN  = 32,
  parameter logic [7:0] SEED = 8'h5A
) (
  input  logic       clk,
  input  logic       chip_en,
  input  logic       out_en,
  input  logic       par_mode,
  output logic [7:0] data_out,
  output logic       data_oe,
  output logic       casc_en
);
  localparam int ADDR_W = $clog2(LEN + 1);

  logic              rst;
  logic              step;
  logic              done;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] addr_nxt;
  logic [2:0]        bit_idx;
  logic [7:0]        rom_q;

  assign rst     = ~out_en;
  assign step    = chip_en & out_en & ~done;
  assign casc_en = done;

  cfgs_seq #(.LEN(LEN), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .step(step), .par(par_mode),
    .addr(addr), .addr_nxt(addr_nxt), .bit_idx(bit_idx), .done(done)
  );

  cfgs_rom #(.LEN(LEN), .SEED(SEED), .ADDR_W(ADDR_W)) u_rom (
    .clk(clk), .raddr(addr_nxt), .rdata(rom_q)
  );

  cfgs_out u_out (
    .clk(clk), .rst(rst), .step(step), .par(par_mode),
    .rom_q(rom_q), .bit_idx(bit_idx), .dout(data_out), .doe(data_oe)
  );
endmodule

// File: rtl/cfgs_chk.sv
module cfgs_chk (
  input logic       clk,
  input logic       chip_en,
  input logic       out_en,
  input logic       par_mode,
  input logic [7:0] data_out,
  input logic       data_oe,
  input logic       casc_en
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (!out_en) armed <= 1'b1;

  AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!armed)
    !(chip_en && out_en) |=> !data_oe);                                   // R1
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!armed)
    !data_oe |-> data_out == 8'h00);                                      // R1
  AST_SERIAL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!armed)
    (chip_en && out_en && !par_mode) |=> data_out[7:1] == 7'd0);          // R4
  AST_CASC_STICKY: assert property (@(posedge clk) disable iff (!armed)
    (casc_en && out_en) |=> casc_en);                                     // R6
  AST_NO_DATA_AFTER_END: assert property (@(posedge clk) disable iff (!armed)
    casc_en |=> !data_oe);                                                // R7
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!armed)
    !out_en |=> (!casc_en && !data_oe));                                  // R8
endmodule

bind cfgs_stream cfgs_chk u_chk (.*);

// File: tb/cfgs_stream_test.sv
module cfgs_stream_test;
  localparam int         LEN = 12;
  localparam logic [7:0] SA  = 8'h5A;
  localparam logic [7:0] SB  = 8'hC3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic ce = 1'b0, oe = 1'b0, par = 1'b0;
  logic [7:0] d_a, d_b;
  logic oe_a, oe_b, c_a, c_b;

  int checks = 0;
  int errors = 0;

  cfgs_stream #(.LEN(LEN), .SEED(SA)) uut (
    .clk(clk), .chip_en(ce), .out_en(oe), .par_mode(par),
    .data_out(d_a), .data_oe(oe_a), .casc_en(c_a));

  cfgs_stream #(.LEN(LEN), .SEED(SB)) u_next (
    .clk(clk), .chip_en(c_a), .out_en(oe), .par_mode(par),
    .data_out(d_b), .data_oe(oe_b), .casc_en(c_b));

  // Model state for both devices
  int         m_addr [2];
  int         m_bit  [2];
  bit         m_done [2];
  logic [7:0] e_d    [2];
  bit         e_oe   [2];

  function automatic logic [7:0] rb(input int i, input logic [7:0] s);
    int unsigned v;
    v = (i * 29 + 32'(s)) ^ (i >> 2);
    return v[7:0];
  endfunction

  task automatic model_edge(input bit ce_i, input bit oe_i, input bit par_i);
    bit pre_casc;
    bit en;
    logic [7:0] b;
    pre_casc = m_done[0];
    for (int k = 0; k < 2; k++) begin
      en = (k == 0) ? ce_i : pre_casc;
      if (!oe_i) begin
        m_addr[k] = 0; m_bit[k] = 0; m_done[k] = 0;
        e_oe[k] = 0; e_d[k] = 8'h00;
      end else if (en && !m_done[k]) begin
        b = rb(m_addr[k], (k == 0) ? SA : SB);
        e_oe[k] = 1;
        e_d[k]  = par_i ? b : {7'b0, b[7 - m_bit[k]]};
        if (par_i || m_bit[k] == 7) begin
          m_done[k] = (m_addr[k] == LEN - 1);
          m_addr[k]++;
          m_bit[k] = 0;
        end else begin
          m_bit[k]++;
        end
      end else begin
        e_oe[k] = 0; e_d[k] = 8'h00;
      end
    end
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Drives inputs (called just after a falling edge), steps the model at the
  // rising edge, and compares at the next falling edge.
  task automatic cyc(input bit ce_i, input bit oe_i, input bit par_i, input string tag);
    ce = ce_i; oe = oe_i; par = par_i;
    @(posedge clk);
    model_edge(ce_i, oe_i, par_i);
    @(negedge clk);
    chk(tag, "data_out", int'(d_a), int'(e_d[0]));
    chk(tag, "data_oe",  int'(oe_a), int'(e_oe[0]));
    chk(tag, "casc_en",  int'(c_a), int'(m_done[0]));
    chk("R9", "next data_out", int'(d_b), int'(e_d[1]));
    chk("R9", "next data_oe",  int'(oe_b), int'(e_oe[1]));
    chk("R9", "next casc_en",  int'(c_b), int'(m_done[1]));
    chk("R9", "bus exclusive", int'(oe_a && oe_b), 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL R1 watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    bit cur_par;
    void'($urandom(32'd2024));
    @(negedge clk);
    // Reset state
    repeat (2) cyc(0, 0, 0, "R8");
    // Parallel: first bytes (content), pause, then run through the end
    repeat (4) cyc(1, 1, 1, "R2");
    repeat (3) cyc(0, 1, 1, "R5");
    repeat (LEN - 5) cyc(1, 1, 1, "R3");
    cyc(1, 1, 1, "R6");
    repeat (LEN + 6) cyc(1, 1, 1, "R7");
    // Reset, serial partial stream, reset mid-stream
    cyc(0, 0, 0, "R8");
    repeat (19) cyc(1, 1, 0, "R4");
    cyc(0, 0, 0, "R8");
    repeat (3) cyc(1, 1, 0, "R8");
    cyc(0, 0, 0, "R8");
    // Serial full chain
    repeat (8 * LEN * 2 + 6) cyc(1, 1, 0, "R6");
    cyc(0, 0, 1, "R8");
    // Random phase
    cur_par = 1;
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 199) == 0) begin
        cur_par = bit'($urandom_range(0, 1));
        cyc(bit'($urandom_range(0, 1)), 0, cur_par, "R8");
      end else begin
        cyc($urandom_range(0, 3) != 0, 1, cur_par, "R5");
      end
    end
    summary();
    $finish;
  end
endmodule